// File: doc/BRIEF.md
# Software Interrupt Target Dispatcher

This block turns one 64-bit software-interrupt request word, issued by a requesting core, into a set of per-core pending bits. Each of up to `NUM_CORES` cores has a four-level affinity fixed by a parameter. The request either names a group of cores or asks for a broadcast. When it names a group, it gives three upper affinity levels and a 16-bit mask over the lowest level. When it asks for a broadcast, every core except the requester is targeted. A configuration table gives the group of each interrupt ID on each core. A request made through the group-0 access path may only raise interrupts that are configured as group 0. A second table marks interrupts that are hardware-backed. Those are reported on a separate inject mask and do not set the local pending bit.

A request is accepted only while the block is idle. The block then visits one core per clock in ascending index order. Each level-0 mask bit is consumed by the first core that claims it. When a non-broadcast request has no mask bits left, the scan ends early. A one-cycle `done` pulse marks the result. The result is held until the next request is accepted.

Top module: `sgi_target_dispatch`

## Requirements
- R1: After reset `busy`, `done`, `pendMask`, `hwMask` and `sgiOneHot` are all zero.
- R2: From acceptance on, `sgiOneHot` is the one-hot decode of the interrupt ID in request bits [27:24].
- R3: Without broadcast, core c is targeted only if its Aff3, Aff2 and Aff1 equal request bits [55:48], [39:32] and [23:16], its Aff0 is below 16, and request bit Aff0 of the list [15:0] is still set. A core whose Aff0 is 16 or more is never targeted.
- R4: When request bit [40] is 1, every core except `reqCore` is targeted, and the affinity fields and the list are ignored.
- R5: Each list bit targets at most one core: the lowest-index core that claims it, after which the bit is removed from the list.
- R6: The scan visits one core per cycle. Its length in busy cycles is N for a broadcast and 0 for an empty list. Otherwise it is k+1 when the list empties at core k, and N when the list never empties.
- R7: With `reqGroup1`=0, a targeted core is only marked when the `sgiGroupCfg` bit at c*16+id is 0 (group 0). With `reqGroup1`=1, either group is marked.
- R8: A permitted target whose `sgiHwCfg` bit at c*16+id is 1 sets bit c of `hwMask` and not of `pendMask`. Otherwise it sets bit c of `pendMask`.
- R9: `reqValid` while busy or done is ignored and does not alter the result.
- R10: `done` is high for exactly one cycle, and `pendMask`, `hwMask` and `sgiOneHot` hold their values until the next acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request strobe, taken when idle |
| reqWord | input | 64 | Request word |
| reqCore | input | IDXW | Index of requesting core |
| reqGroup1 | input | 1 | 1 = group-1 access path |
| sgiGroupCfg | input | NUM_CORES*16 | Group per core and ID (1 = group 1) |
| sgiHwCfg | input | NUM_CORES*16 | Hardware-backed flag per core and ID |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle completion pulse |
| sgiOneHot | output | 16 | Decoded interrupt ID |
| pendMask | output | NUM_CORES | Cores whose pending bit is set |
| hwMask | output | NUM_CORES | Cores that get a hardware inject |

## Verification
Two cases are hard to reach from the ports. In the first, two cores share an identical affinity, so a list bit must be consumed by the lower core only and the scan must stop right after it. In the second, a core's Aff0 has a low nibble that aliases a list bit while its full value is 16 or more. The default affinity set builds in both. Directed requests aim at those bits, and random requests draw their affinity fields from the small set that the cores actually use, so that matches, partial drains and early exits occur often. A second request is injected in the middle of a broadcast scan to show it is dropped.

// File: rtl/sgi_dispatch_pkg.sv
package sgi_dispatch_pkg;
  localparam int SGI_IDS = 16;
  localparam int LIST_LO = 0;
  localparam int AFF1_LO = 16;
  localparam int ID_LO   = 24;
  localparam int AFF2_LO = 32;
  localparam int BCAST_B = 40;
  localparam int AFF3_LO = 48;

  typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_DONE} scanState_t;

  typedef struct packed {
    logic load;
    logic visit;
  } dispStrobe_t;
endpackage

// File: rtl/sgi_dispatch_ctrl.sv
module sgi_dispatch_ctrl
  import sgi_dispatch_pkg::*;
#(
  parameter int NUM_CORES = 8,
  localparam int IDXW = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqValid,
  input  logic            loadSkip,
  input  logic            drained,
  output dispStrobe_t     strobe,
  output logic [IDXW-1:0] idx,
  output logic            busy,
  output logic            done
);
  localparam logic [IDXW-1:0] LAST = IDXW'(NUM_CORES - 1);

  scanState_t state;

  always_comb begin
    strobe.load  = (state == ST_IDLE) && reqValid;
    strobe.visit = (state == ST_SCAN);
  end

  assign busy = (state == ST_SCAN);
  assign done = (state == ST_DONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      idx   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (reqValid) begin
          idx   <= '0;
          state <= loadSkip ? ST_DONE : ST_SCAN;
        end
        ST_SCAN: begin
          if (drained || idx == LAST) state <= ST_DONE;
          else idx <= idx + IDXW'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R6
  scan_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !drained && idx != LAST) |=> (busy && idx == $past(idx) + IDXW'(1)));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
endmodule

// File: rtl/sgi_dispatch_dp.sv
module sgi_dispatch_dp
  import sgi_dispatch_pkg::*;
#(
  parameter int NUM_CORES = 8,
  parameter logic [NUM_CORES*32-1:0] CORE_AFF = '0,
  localparam int IDXW = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  dispStrobe_t                  strobe,
  input  logic [IDXW-1:0]              idx,
  input  logic [63:0]                  reqWord,
  input  logic [IDXW-1:0]              reqCore,
  input  logic                         reqGroup1,
  input  logic [NUM_CORES*SGI_IDS-1:0] sgiGroupCfg,
  input  logic [NUM_CORES*SGI_IDS-1:0] sgiHwCfg,
  output logic                         loadSkip,
  output logic                         drained,
  output logic [SGI_IDS-1:0]           sgiOneHot,
  output logic [NUM_CORES-1:0]         pendMask,
  output logic [NUM_CORES-1:0]         hwMask
);
  logic [3:0]      sgiId;
  logic            bcast, allowG1;
  logic [23:0]     upperAff;
  logic [IDXW-1:0] srcCore;
  logic [15:0]     remList;

  logic [31:0] coreAff;
  logic        affHit, hit, grpOne, hwBacked, permit;
  logic [15:0] nextList;
  logic        unusedBits;

  assign unusedBits = ^{reqWord[63:56], reqWord[47:41], reqWord[31:28]};
  assign loadSkip = !reqWord[BCAST_B] && (reqWord[LIST_LO +: 16] == '0);

  always_comb begin
    coreAff  = CORE_AFF[int'(idx)*32 +: 32];
    affHit   = (coreAff[31:8] == upperAff) && (coreAff[7:0] < 8'd16) &&
               remList[coreAff[3:0]];
    hit      = bcast ? (idx != srcCore) : affHit;
    grpOne   = sgiGroupCfg[int'(idx)*SGI_IDS + int'(sgiId)];
    hwBacked = sgiHwCfg[int'(idx)*SGI_IDS + int'(sgiId)];
    permit   = hit && (!grpOne || allowG1);
    nextList = remList;
    if (!bcast && affHit) nextList[coreAff[3:0]] = 1'b0;
    drained  = !bcast && (nextList == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sgiId     <= '0;
      bcast     <= 1'b0;
      allowG1   <= 1'b0;
      upperAff  <= '0;
      srcCore   <= '0;
      remList   <= '0;
      sgiOneHot <= '0;
      pendMask  <= '0;
      hwMask    <= '0;
    end else if (strobe.load) begin
      sgiId     <= reqWord[ID_LO +: 4];
      bcast     <= reqWord[BCAST_B];
      allowG1   <= reqGroup1;
      upperAff  <= {reqWord[AFF3_LO +: 8], reqWord[AFF2_LO +: 8], reqWord[AFF1_LO +: 8]};
      srcCore   <= reqCore;
      remList   <= reqWord[LIST_LO +: 16];
      sgiOneHot <= SGI_IDS'(1) << reqWord[ID_LO +: 4];
      pendMask  <= '0;
      hwMask    <= '0;
    end else if (strobe.visit) begin
      remList <= nextList;
      if (permit) begin
        if (hwBacked) hwMask[idx]   <= 1'b1;
        else          pendMask[idx] <= 1'b1;
      end
    end
  end

  // R2
  id_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(sgiOneHot));

  // R4
  bcast_self_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.visit && bcast && idx == srcCore) |=> ($stable(pendMask) && $stable(hwMask)));

  // R7
  group_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.visit && !allowG1 && grpOne) |=> ($stable(pendMask) && $stable(hwMask)));

  // R8
  hw_route_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.visit && hwBacked) |=> $stable(pendMask));

  // R10
  hold_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.load && !strobe.visit) |=> ($stable(pendMask) && $stable(hwMask) && $stable(sgiOneHot)));
endmodule

// File: rtl/sgi_target_dispatch.sv
module sgi_target_dispatch
  import sgi_dispatch_pkg::*;
#(
  parameter int NUM_CORES = 8,
  parameter logic [NUM_CORES*32-1:0] CORE_AFF = {
    32'h0000_0014, 32'h0000_0105, 32'h0000_0105, 32'h0000_0104,
    32'h0000_0003, 32'h0000_0002, 32'h0000_0001, 32'h0000_0000},
  localparam int IDXW = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       reqValid,
  input  logic [63:0]                reqWord,
  input  logic [IDXW-1:0]            reqCore,
  input  logic                       reqGroup1,
  input  logic [NUM_CORES*16-1:0]    sgiGroupCfg,
  input  logic [NUM_CORES*16-1:0]    sgiHwCfg,
  output logic                       busy,
  output logic                       done,
  output logic [15:0]                sgiOneHot,
  output logic [NUM_CORES-1:0]       pendMask,
  output logic [NUM_CORES-1:0]       hwMask
);
  dispStrobe_t     strobe;
  logic [IDXW-1:0] idx;
  logic            loadSkip, drained;

  sgi_dispatch_ctrl #(.NUM_CORES(NUM_CORES)) ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .loadSkip(loadSkip),
    .drained(drained), .strobe(strobe), .idx(idx), .busy(busy), .done(done));

  sgi_dispatch_dp #(.NUM_CORES(NUM_CORES), .CORE_AFF(CORE_AFF)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .idx(idx), .reqWord(reqWord),
    .reqCore(reqCore), .reqGroup1(reqGroup1), .sgiGroupCfg(sgiGroupCfg),
    .sgiHwCfg(sgiHwCfg), .loadSkip(loadSkip), .drained(drained),
    .sgiOneHot(sgiOneHot), .pendMask(pendMask), .hwMask(hwMask));
endmodule

// File: tb/sgi_target_dispatch_tb_top.sv
module sgi_target_dispatch_tb_top;
  localparam int N = 8;
  localparam int IW = 3;
  localparam logic [N*32-1:0] AFF = {
    32'h0000_0014, 32'h0000_0105, 32'h0000_0105, 32'h0000_0104,
    32'h0000_0003, 32'h0000_0002, 32'h0000_0001, 32'h0000_0000};

  logic clk = 0;
  logic rstN = 0;
  logic reqValid = 0;
  logic [63:0] reqWord = '0;
  logic [IW-1:0] reqCore = '0;
  logic reqGroup1 = 0;
  logic [N*16-1:0] grpCfg = '0;
  logic [N*16-1:0] hwCfg = '0;
  logic busy, done;
  logic [15:0] sgiOneHot;
  logic [N-1:0] pendMask, hwMask;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  sgi_target_dispatch #(.NUM_CORES(N), .CORE_AFF(AFF)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWord(reqWord),
    .reqCore(reqCore), .reqGroup1(reqGroup1), .sgiGroupCfg(grpCfg),
    .sgiHwCfg(hwCfg), .busy(busy), .done(done), .sgiOneHot(sgiOneHot),
    .pendMask(pendMask), .hwMask(hwMask));

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void model(input logic [63:0] w, input int rc, input bit g1,
                                output logic [N-1:0] pe, output logic [N-1:0] hw,
                                output int len);
    logic [15:0] lst = w[15:0];
    bit bc = w[40];
    int id = int'(w[27:24]);
    pe = '0; hw = '0; len = 0;
    for (int c = 0; c < N; c++) begin
      logic [31:0] a = AFF[c*32 +: 32];
      bit hit;
      if (!bc && lst == 0) break;
      len = c + 1;
      if (bc) hit = (c != rc);
      else begin
        hit = (a[31:24] == w[55:48]) && (a[23:16] == w[39:32]) &&
              (a[15:8] == w[23:16]) && (a[7:0] < 16) && lst[a[3:0]];
        if (hit) lst[a[3:0]] = 1'b0;
      end
      if (hit && (!grpCfg[c*16+id] || g1)) begin
        if (hwCfg[c*16+id]) hw[c] = 1'b1;
        else pe[c] = 1'b1;
      end
    end
  endfunction

  task automatic runReq(string tag, logic [63:0] w, int rc, bit g1, bit intrude);
    logic [N-1:0] ePe, eHw;
    int eLen, cnt, guard;
    model(w, rc, g1, ePe, eHw, eLen);
    reqWord = w; reqCore = IW'(rc); reqGroup1 = g1; reqValid = 1;
    @(negedge clk);
    reqValid = 0;
    cnt = 0; guard = 0;
    while (!done && guard < 50) begin
      if (busy) cnt++;
      guard++;
      if (intrude && cnt == 2) begin
        reqWord = ~w; reqCore = IW'(rc + 1); reqGroup1 = ~g1; reqValid = 1;
      end else reqValid = 0;
      @(negedge clk);
    end
    reqValid = 0;
    check({tag, " R6 scan length"}, 64'(cnt), 64'(eLen));
    check({tag, " R2 id one-hot"}, 64'(sgiOneHot), 64'(16'd1 << w[27:24]));
    check({tag, " R3/R7 pending"}, 64'(pendMask), 64'(ePe));
    check({tag, " R8 hw inject"}, 64'(hwMask), 64'(eHw));
    @(negedge clk);
    check({tag, " R10 done pulse"}, 64'(done), 64'd0);
    check({tag, " R10 hold"}, 64'({pendMask, hwMask, sgiOneHot}),
          64'({ePe, eHw, 16'd1 << w[27:24]}));
  endtask

  function automatic logic [63:0] mkWord(logic [7:0] a3, logic [7:0] a2, logic [7:0] a1,
                                         logic [3:0] id, bit bc, logic [15:0] lst);
    logic [63:0] w = '0;
    w[55:48] = a3; w[39:32] = a2; w[23:16] = a1; w[27:24] = id; w[40] = bc; w[15:0] = lst;
    return w;
  endfunction

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset", 64'({busy, done, pendMask, hwMask, sgiOneHot}), 64'd0);
    rstN = 1;
    @(negedge clk);
    check("R1 idle after reset", 64'({busy, done}), 64'd0);

    runReq("R3 cores0and2", mkWord(0, 0, 0, 4'd3, 0, 16'h0005), 7, 1, 0);
    runReq("R3 aff1 miss", mkWord(0, 0, 0, 4'd1, 0, 16'h0010), 0, 1, 0);
    runReq("R3 aff0 ge16", mkWord(0, 0, 0, 4'd2, 0, 16'h0010), 1, 1, 0);
    runReq("R5 duplicate", mkWord(0, 0, 1, 4'd9, 0, 16'h0020), 0, 1, 0);
    runReq("R6 empty list", mkWord(0, 0, 0, 4'd4, 0, 16'h0000), 0, 1, 0);
    runReq("R6 early exit", mkWord(0, 0, 0, 4'd5, 0, 16'h0002), 0, 1, 0);
    runReq("R4 broadcast", mkWord(8'h77, 8'h12, 8'h34, 4'd6, 1, 16'h0000), 3, 1, 0);
    grpCfg = '1;
    runReq("R7 group0 path", mkWord(0, 0, 0, 4'd7, 1, 16'h0), 0, 0, 0);
    runReq("R7 group1 path", mkWord(0, 0, 0, 4'd7, 1, 16'h0), 0, 1, 0);
    grpCfg = '0; hwCfg = '1;
    runReq("R8 hw backed", mkWord(0, 0, 0, 4'd8, 0, 16'h000f), 5, 1, 0);
    hwCfg = '0;
    runReq("R9 intrusion", mkWord(0, 0, 0, 4'd10, 1, 16'h0), 2, 1, 1);

    for (int i = 0; i < 300; i++) begin
      logic [63:0] w = {$urandom, $urandom};
      grpCfg = {$urandom, $urandom, $urandom, $urandom};
      hwCfg  = {$urandom, $urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom, $urandom};
      if ($urandom_range(3) != 0) begin
        w[55:48] = ($urandom_range(7) == 0) ? 8'(1) : 8'(0);
        w[39:32] = ($urandom_range(7) == 0) ? 8'(1) : 8'(0);
        w[23:16] = 8'($urandom_range(1));
        if ($urandom_range(1) == 0) w[15:0] = w[15:0] & 16'h007f;
      end
      w[40] = ($urandom_range(3) == 0);
      runReq("random", w, int'($urandom_range(N - 1)), bit'($urandom_range(1)),
             ($urandom_range(9) == 0) && w[40]);
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule